// File: doc/BRIEF.md
# Serial Flash Write-Protection Unit

This block holds the status register and the write-protection decisions of a serial NOR flash device. It receives one decoded command per clock: set or clear the write-enable latch, write or read the status register, program a page, erase a sector, or erase the whole array. It keeps the status byte visible at all times and answers every array modification with a one-cycle grant or deny pulse. The serial shifter in front of it and the memory array behind it are out of scope.

The array has 512 sectors of 64 KiB. A 4-bit protect level and a top/bottom select in the status register choose a region that cannot be modified. This region is a power-of-two number of sectors at either end of the array. An active-low write-protect pin, together with the status-register lock bit, decides whether the status register may be rewritten.

Top module: `flash_wp_unit`

## Requirements
- R1: After reset the status byte reads 0x00 and neither opGrant nor opDeny is high.
- R2: The status byte holds the lock bit in bit 7, the protect-level MSB in bit 6, the top/bottom select in bit 5, the protect-level bits 2..0 in bits 4..2, the write-enable latch in bit 1, and 0 in bit 0. A write-enable command (code 0) sets bit 1 and a write-disable command (code 1) clears it, both visible from the clock edge that takes the command.
- R3: A status write (code 2) taken while the latch is set copies cmdData bits 7..2 into status bits 7..2 and clears the latch. cmdData bits 1..0 are not stored.
- R4: A status write taken while status bit 7 is 1 and wpPinN is 0 leaves status bits 7..2 unchanged, and the latch still clears.
- R5: In every other combination of wpPinN and status bit 7, a status write with the latch set is stored. wpPinN is sampled in the command's own cycle.
- R6: A status write, program (code 4), sector erase (code 5) or bulk erase (code 6) taken while the latch is clear changes no status bit. For the three array commands, opDeny pulses. A status read (code 3) and code 7 change nothing.
- R7: With protect level n (status bits 6,4,3,2), the number of protected sectors is 0 for n = 0 and otherwise min(2^(n-1), 512).
- R8: With the top/bottom select at 0, the protected sectors are [512-count, 512). With the select at 1, they are [0, count).
- R9: A program or sector erase with the latch set pulses opGrant when its target sector is unprotected and opDeny when it is protected. The pulse lasts exactly one cycle and appears in the cycle after the command. opGrant and opDeny are never high together.
- R10: The latch clears after every program or erase taken while it was set, whether the operation was granted or denied.
- R11: A bulk erase with the latch set pulses opDeny when the protected count is nonzero, and opGrant otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | A decoded command is present this cycle |
| cmdCode | input | 3 | Command code (see R2, R3, R6) |
| cmdData | input | 8 | Status write data byte |
| cmdSector | input | 9 | Target sector of a program or sector erase |
| wpPinN | input | 1 | Write-protect pin, active low |
| statusByte | output | 8 | Current status register |
| opGrant | output | 1 | Array operation permitted (one-cycle pulse) |
| opDeny | output | 1 | Array operation refused (one-cycle pulse) |

## Verification
Two pairs of functions can land on the same clock edge.

- **Status write and latch clear.** Both happen on one edge. The bench confirms that the new protection bits appear while bit 1 drops.
- **Pin change and status write.** wpPinN can change in the very cycle of a status write. The random phase toggles the pin on every cycle, and a behavioural model sampling the pin at that edge judges the stored value.

A status write followed immediately by a program is also driven back to back. This checks that the program is judged against the new protect level and not the old one.

// File: rtl/flash_wp_pkg.sv
package flash_wp_pkg;

  typedef enum logic [2:0] {
    CMD_WREN   = 3'd0,
    CMD_WRDI   = 3'd1,
    CMD_WRSR   = 3'd2,
    CMD_RDSR   = 3'd3,
    CMD_PROG   = 3'd4,
    CMD_SERASE = 3'd5,
    CMD_BERASE = 3'd6,
    CMD_NOP    = 3'd7
  } cmd_e;

  // strobes from control to datapath
  typedef struct packed {
    logic setWel;
    logic clrWel;
    logic loadSr;
    logic arrayReq;  // an array-modifying command arrived
    logic arrayGo;   // it is enabled and must be judged against protection
    logic bulkOp;    // it covers the whole array
  } wpStrobe_t;

endpackage

// File: rtl/wp_ctrl.sv
module wp_ctrl
  import flash_wp_pkg::*;
(
  input  logic       cmdValid,
  input  logic [2:0] cmdCode,
  input  logic       welNow,
  input  logic       srwdNow,
  input  logic       wpPinN,
  output wpStrobe_t  strobe
);

  cmd_e code;
  logic srLocked;

  assign code     = cmd_e'(cmdCode);
  assign srLocked = srwdNow && !wpPinN;

  always_comb begin
    strobe = '0;
    if (cmdValid) begin
      unique case (code)
        CMD_WREN: strobe.setWel = 1'b1;
        CMD_WRDI: strobe.clrWel = 1'b1;
        CMD_WRSR: begin
          strobe.clrWel = welNow;
          strobe.loadSr = welNow && !srLocked;
        end
        CMD_PROG, CMD_SERASE: begin
          strobe.arrayReq = 1'b1;
          strobe.arrayGo  = welNow;
          strobe.clrWel   = welNow;
        end
        CMD_BERASE: begin
          strobe.arrayReq = 1'b1;
          strobe.arrayGo  = welNow;
          strobe.bulkOp   = 1'b1;
          strobe.clrWel   = welNow;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/wp_datapath.sv
module wp_datapath
  import flash_wp_pkg::*;
#(
  parameter int NumSectors = 512,
  parameter int SecBits    = $clog2(NumSectors),
  parameter int LevelBits  = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  wpStrobe_t          strobe,
  input  logic [7:0]         cmdData,
  input  logic [SecBits-1:0] cmdSector,
  output logic [7:0]         statusByte,
  output logic               welNow,
  output logic               srwdNow,
  output logic               opGrant,
  output logic               opDeny
);

  localparam int CntW = SecBits + 1;
  localparam logic [CntW-1:0] TotalCnt = CntW'(NumSectors);

  logic                 welQ, srwdQ, tbSelQ;
  logic [LevelBits-1:0] levelQ;
  logic [CntW-1:0]      protCount;
  logic [31:0]          powCount;
  logic [LevelBits-1:0] shiftAmt;
  logic [CntW-1:0]      secWide;
  logic                 secProt, anyProt, allowed;

  // protected sector count: 0, else min(2^(n-1), NumSectors)
  always_comb begin
    shiftAmt = levelQ - LevelBits'(1);
    powCount = 32'd1 << shiftAmt;
    if (levelQ == '0)
      protCount = '0;
    else if (powCount >= 32'(NumSectors))
      protCount = TotalCnt;
    else
      protCount = powCount[CntW-1:0];
  end

  assign secWide = {1'b0, cmdSector};
  assign secProt = tbSelQ ? (secWide < protCount)
                          : (secWide >= (TotalCnt - protCount));
  assign anyProt = (protCount != '0);
  assign allowed = strobe.bulkOp ? !anyProt : !secProt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      welQ    <= 1'b0;
      srwdQ   <= 1'b0;
      tbSelQ  <= 1'b0;
      levelQ  <= '0;
      opGrant <= 1'b0;
      opDeny  <= 1'b0;
    end else begin
      if (strobe.loadSr) begin
        srwdQ  <= cmdData[7];
        tbSelQ <= cmdData[5];
        levelQ <= {cmdData[6], cmdData[4:2]};
      end
      if (strobe.clrWel)
        welQ <= 1'b0;
      else if (strobe.setWel)
        welQ <= 1'b1;
      opGrant <= strobe.arrayGo && allowed;
      opDeny  <= strobe.arrayReq && !(strobe.arrayGo && allowed);
    end
  end

  assign statusByte = {srwdQ, levelQ[3], tbSelQ, levelQ[2:0], welQ, 1'b0};
  assign welNow     = welQ;
  assign srwdNow    = srwdQ;

endmodule

// File: rtl/flash_wp_unit.sv
module flash_wp_unit
  import flash_wp_pkg::*;
#(
  parameter int NumSectors = 512,
  parameter int SecBits    = $clog2(NumSectors)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmdValid,
  input  logic [2:0]         cmdCode,
  input  logic [7:0]         cmdData,
  input  logic [SecBits-1:0] cmdSector,
  input  logic               wpPinN,
  output logic [7:0]         statusByte,
  output logic               opGrant,
  output logic               opDeny
);

  wpStrobe_t strobe;
  logic      welNow, srwdNow;

  wp_ctrl u_ctrl (
    .cmdValid (cmdValid),
    .cmdCode  (cmdCode),
    .welNow   (welNow),
    .srwdNow  (srwdNow),
    .wpPinN   (wpPinN),
    .strobe   (strobe)
  );

  wp_datapath #(
    .NumSectors (NumSectors),
    .SecBits    (SecBits),
    .LevelBits  (4)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobe     (strobe),
    .cmdData    (cmdData),
    .cmdSector  (cmdSector),
    .statusByte (statusByte),
    .welNow     (welNow),
    .srwdNow    (srwdNow),
    .opGrant    (opGrant),
    .opDeny     (opDeny)
  );

endmodule

// File: rtl/flash_wp_checker.sv
module flash_wp_checker #(
  parameter int SecBits = 9
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cmdValid,
  input logic [2:0]         cmdCode,
  input logic [7:0]         cmdData,
  input logic [SecBits-1:0] cmdSector,
  input logic               wpPinN,
  input logic [7:0]         statusByte,
  input logic               opGrant,
  input logic               opDeny
);

  logic isArray;
  assign isArray = cmdValid && (cmdCode == 3'd4 || cmdCode == 3'd5 || cmdCode == 3'd6);

  a_r9_grant_deny_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(opGrant && opDeny));

  a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdCode == 3'd0) |=> statusByte[1]);

  a_r3_wrsr_load: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdCode == 3'd2 && statusByte[1] && !(statusByte[7] && !wpPinN))
    |=> (statusByte[7:2] == $past(cmdData[7:2])) && !statusByte[1]);

  a_r4_locked_sr: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdCode == 3'd2 && statusByte[7] && !wpPinN)
    |=> $stable(statusByte[7:2]));

  a_r6_no_grant_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (isArray && !statusByte[1]) |=> (opDeny && !opGrant));

  a_r10_wel_clears: assert property (@(posedge clk) disable iff (!rst_n)
    isArray |=> !statusByte[1]);

  a_r11_bulk_refused: assert property (@(posedge clk) disable iff (!rst_n)
    (cmdValid && cmdCode == 3'd6 && statusByte[1] && ({statusByte[6], statusByte[4:2]} != 4'd0))
    |=> opDeny);

  a_r9_pulse_needs_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    (!isArray) |=> !(opGrant || opDeny));

endmodule

bind flash_wp_unit flash_wp_checker #(.SecBits(SecBits)) chk (.*);

// File: tb/flash_wp_unit_test.sv
module flash_wp_unit_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmdValid = 1'b0;
  logic [2:0] cmdCode = 3'd7;
  logic [7:0] cmdData = '0;
  logic [8:0] cmdSector = '0;
  logic       wpPinN = 1'b1;
  logic [7:0] statusByte;
  logic       opGrant, opDeny;

  int total = 0;
  int bad = 0;
  bit done = 0;
  bit running = 0;
  string curTag = "R1";

  // behavioural reference state
  int  mWel, mSrwd, mLevel, mTb, mGrant, mDeny;

  always #10 clk = ~clk;

  flash_wp_unit uut (
    .clk(clk), .rst_n(rst_n), .cmdValid(cmdValid), .cmdCode(cmdCode),
    .cmdData(cmdData), .cmdSector(cmdSector), .wpPinN(wpPinN),
    .statusByte(statusByte), .opGrant(opGrant), .opDeny(opDeny)
  );

  function automatic int protCnt(int n);
    if (n == 0) return 0;
    if ((1 << (n - 1)) > 512) return 512;
    return 1 << (n - 1);
  endfunction

  function automatic int isProt(int s, int n, int tb);
    int c = protCnt(n);
    if (tb != 0) return (s < c) ? 1 : 0;
    return (s >= 512 - c) ? 1 : 0;
  endfunction

  function automatic logic [7:0] modelByte();
    logic [7:0] b;
    b[7] = mSrwd[0]; b[6] = mLevel[3]; b[5] = mTb[0];
    b[4:2] = mLevel[2:0]; b[1] = mWel[0]; b[0] = 1'b0;
    return b;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mWel = 0; mSrwd = 0; mLevel = 0; mTb = 0; mGrant = 0; mDeny = 0;
    end else begin
      mGrant = 0; mDeny = 0;
      if (cmdValid) begin
        case (cmdCode)
          3'd0: mWel = 1;
          3'd1: mWel = 0;
          3'd2: if (mWel != 0) begin
            if (!(mSrwd != 0 && wpPinN == 1'b0)) begin
              mSrwd = cmdData[7]; mTb = cmdData[5];
              mLevel = {cmdData[6], cmdData[4:2]};
            end
            mWel = 0;
          end
          3'd4, 3'd5: begin
            if (mWel != 0 && isProt(cmdSector, mLevel, mTb) == 0) mGrant = 1;
            else mDeny = 1;
            mWel = 0;
          end
          3'd6: begin
            if (mWel != 0 && protCnt(mLevel) == 0) mGrant = 1;
            else mDeny = 1;
            mWel = 0;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic check(string tag, int actual, int expected);
    total++;
    if (actual != expected) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, actual, expected);
    end
  endtask

  // model comparison on every clock
  always @(negedge clk) begin
    if (running) begin
      check({curTag, " status"}, statusByte, modelByte());
      check({curTag, " grant"}, opGrant, mGrant);
      check({curTag, " deny"}, opDeny, mDeny);
    end
  end

  task automatic doCmd(int code, int data, int sector);
    cmdValid  = 1'b1;
    cmdCode   = code[2:0];
    cmdData   = data[7:0];
    cmdSector = sector[8:0];
    @(negedge clk);
    cmdValid  = 1'b0;
    cmdCode   = 3'd7;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 status", statusByte, 8'h00);
    check("R1 pulses", {opGrant, opDeny}, 0);
    running = 1;

    // R2 latch set/clear
    curTag = "R2";
    doCmd(0, 0, 0); check("R2 wren", statusByte, 8'h02);
    doCmd(1, 0, 0); check("R2 wrdi", statusByte, 8'h00);

    // R6 disabled commands are ignored
    curTag = "R6";
    doCmd(2, 8'hFF, 0); check("R6 wrsr ignored", statusByte, 8'h00);
    doCmd(4, 0, 5);     check("R6 prog deny", {opGrant, opDeny}, 1);
    doCmd(6, 0, 0);     check("R6 bulk deny", {opGrant, opDeny}, 1);
    doCmd(3, 0, 0);     check("R6 rdsr no change", statusByte, 8'h00);

    // R3 load, data bits 1..0 dropped, latch cleared
    curTag = "R3";
    doCmd(0, 0, 0); doCmd(2, 8'h83, 0); check("R3 load", statusByte, 8'h80);

    // R4 locked by pin low with lock bit set
    curTag = "R4";
    wpPinN = 1'b0;
    doCmd(0, 0, 0); doCmd(2, 8'h00, 0); check("R4 locked", statusByte, 8'h80);

    // R5 pin high: writable even with lock bit
    curTag = "R5";
    wpPinN = 1'b1;
    doCmd(0, 0, 0); doCmd(2, 8'h00, 0); check("R5 unlocked", statusByte, 8'h00);
    wpPinN = 1'b0;
    doCmd(0, 0, 0); doCmd(2, 8'h80, 0); check("R5 pin low lock clear", statusByte, 8'h80);
    wpPinN = 1'b1;
    doCmd(0, 0, 0); doCmd(2, 8'h00, 0);

    // R7 R8 R9 R10 R11 protection sweep
    for (int tb = 0; tb < 2; tb++) begin
      for (int n = 0; n < 16; n++) begin
        int c;
        int edgeS;
        int sec[5];
        int d;
        c = protCnt(n);
        d = ((n & 8) << 3) | (tb << 5) | ((n & 7) << 2);
        curTag = "R7";
        doCmd(0, 0, 0); doCmd(2, d, 0);
        check("R7 level stored", statusByte, d);
        edgeS = (tb != 0) ? c : 512 - c;
        sec[0] = 0; sec[1] = 511;
        sec[2] = (edgeS > 511) ? 511 : edgeS;
        sec[3] = (edgeS - 1 < 0) ? 0 : edgeS - 1;
        sec[4] = (edgeS + 1 > 511) ? 511 : edgeS + 1;
        for (int k = 0; k < 5; k++) begin
          int p;
          p = isProt(sec[k], n, tb);
          curTag = "R8";
          doCmd(0, 0, 0); doCmd(4 + (k & 1), 0, sec[k]);
          check("R8 R9 sector verdict", {opGrant, opDeny}, p ? 1 : 2);
          check("R10 latch cleared", statusByte[1], 0);
        end
        curTag = "R11";
        doCmd(0, 0, 0); doCmd(6, 0, 0);
        check("R11 bulk verdict", {opGrant, opDeny}, (c != 0) ? 1 : 2);
      end
    end

    // random phase: pin may toggle in any cycle, including status writes
    curTag = "R5";
    doCmd(0, 0, 0); doCmd(2, 8'h00, 0);
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = $urandom_range(0, 9);
      wpPinN = ($urandom_range(0, 1) == 1);
      if (r >= 7) doCmd(0, 0, 0);
      else doCmd(r, $urandom_range(0, 255), $urandom_range(0, 511));
    end

    running = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule